// File: doc/BRIEF.md
# Maskable 32-Source Interrupt Aggregator

The block gathers a set of synchronous interrupt source lines into one pending register and presents a single level-sensitive request to a host processor. Each source line sets its own pending bit on any clock cycle in which it is high. An enable register then decides which pending bits are allowed to raise the combined request. Source n maps to bit n of both registers.

The host reaches the two registers through a small memory-mapped slave port that has an address, write and read strobes, and 32-bit data. The enable register sits at byte offset 0x00 and the pending status register at byte offset 0x10. The host clears pending bits by writing the status register: a bit written as 0 is cleared and a bit written as 1 is left alone. The usual way to clear one source is to read the status, clear that one bit, and write the value back. A source that fires after the host's read must survive that write-back. The block therefore tracks which sources have fired since the last status access, and a write cannot clear those bits.

Top module: `irq_gather`

## Requirements
- R1: After reset the enable register reads 0, the status register reads 0 and irqOut is low.
- R2: A write to offset 0x00 loads all 32 bits of the enable register. A read of offset 0x00 returns the last value written, and the value stays until the next write to 0x00. A 1 in bit n enables source n.
- R3: Pending bit n is set at the end of any cycle in which srcIn[n] is high, whatever the enable register holds.
- R4: A read of offset 0x10 returns all 32 pending bits, whatever the enable register holds. rdData is combinational and valid in the same cycle as rdEn. When rdEn is low, rdData is 0.
- R5: A write to offset 0x10 clears each unprotected pending bit written as 0 and keeps each bit written as 1.
- R6: If srcIn[n] is high in the same cycle that a status write clears bit n, bit n ends up set.
- R7: A bit is protected if its source was high in any cycle since the most recent read or write of offset 0x10, counting the cycle of that access. A status write never clears a protected bit.
- R8: Writing 0x00000000 to offset 0x10 when no bit is protected clears every pending bit. Writing 0 to offset 0x00 disables every source.
- R9: irqOut is registered. In each cycle it equals the OR, over all bits, of pending AND enable as they stood in the previous cycle.
- R10: A write to any offset other than 0x00 and 0x10 changes neither register. A read of any such offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC (32) | Interrupt source lines, synchronous to clk |
| addr | input | ADDR_W (8) | Byte address of the register access |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle |
| wrData | input | NUM_SRC (32) | Write data |
| rdData | output | NUM_SRC (32) | Read data, valid in the cycle rdEn is high |
| irqOut | output | 1 | Combined level-sensitive interrupt request |

## Verification
Two functions can land in the same cycle: a source setting its pending bit, and a status write clearing that same bit. A source can also fire between the host's status read and its write-back. Directed sequences raise a source in the exact cycle of a clearing write, and again in the gap between a read and its write-back. A long random run then mixes sparse source pulses with reads, writes and write-backs at random. The bench judges every read value and every irqOut level against a model built from the set-wins and protection rules.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  typedef struct packed {
    logic wrMask;
    logic wrStat;
    logic rdMask;
    logic rdStat;
  } strobe_t;
endpackage

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
  import irq_gather_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int MASK_OFS = 'h00,
  parameter int STAT_OFS = 'h10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] MaskAddr = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] StatAddr = ADDR_W'(STAT_OFS);

  logic hitMask;
  logic hitStat;

  assign hitMask = (addr == MaskAddr);
  assign hitStat = (addr == StatAddr);

  always_comb begin
    stb        = '0;
    stb.wrMask = wrEn & hitMask;
    stb.wrStat = wrEn & hitStat;
    stb.rdMask = rdEn & hitMask;
    stb.rdStat = rdEn & hitStat;
  end
endmodule

// File: rtl/irq_gather_dp.sv
module irq_gather_dp
  import irq_gather_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  output logic [NUM_SRC-1:0] pendQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] keepVec;
  logic               statAccess;

  assign statAccess = stb.wrStat | stb.rdStat;
  assign keepVec    = stb.wrStat ? wrData : '1;

  // One cell per source: pending flag plus a flag for firing since the last status access
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    logic pendBit;
    logic protBit;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendBit <= 1'b0;
        protBit <= 1'b0;
      end else begin
        pendBit <= (pendBit & (keepVec[i] | protBit)) | srcIn[i];
        protBit <= srcIn[i] | (protBit & ~statAccess);
      end
    end
    assign pendQ[i] = pendBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (stb.wrMask) begin
      maskQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
    end else begin
      irqOut <= |(pendQ & maskQ);
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.rdMask) begin
      rdData = maskQ;
    end else if (stb.rdStat) begin
      rdData = pendQ;
    end
  end
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_gather_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int ADDR_W   = 8,
  parameter int MASK_OFS = 'h00,
  parameter int STAT_OFS = 'h10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut
);
  strobe_t            stb;
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] maskQ;

  irq_gather_ctrl #(
    .ADDR_W  (ADDR_W),
    .MASK_OFS(MASK_OFS),
    .STAT_OFS(STAT_OFS)
  ) u_ctrl (
    .addr(addr),
    .wrEn(wrEn),
    .rdEn(rdEn),
    .stb (stb)
  );

  irq_gather_dp #(
    .NUM_SRC(NUM_SRC)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .srcIn (srcIn),
    .wrData(wrData),
    .rdData(rdData),
    .pendQ (pendQ),
    .maskQ (maskQ),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
  parameter int NUM_SRC  = 32,
  parameter int ADDR_W   = 8,
  parameter int MASK_OFS = 'h00,
  parameter int STAT_OFS = 'h10
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIn,
  input logic [ADDR_W-1:0]  addr,
  input logic               wrEn,
  input logic               rdEn,
  input logic [NUM_SRC-1:0] wrData,
  input logic [NUM_SRC-1:0] rdData,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] pendQ,
  input logic [NUM_SRC-1:0] maskQ
);
  localparam logic [ADDR_W-1:0] MaskAddr = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] StatAddr = ADDR_W'(STAT_OFS);

  // R3 and R6: every source high in the last cycle shows up as pending
  a_r3_source_sets: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((pendQ & $past(srcIn)) == $past(srcIn)));

  // R2: the enable register only moves on a write to its offset
  a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == MaskAddr) |=> $stable(maskQ));

  // R5: bits written as 1 on a status write stay pending
  a_r5_ones_keep: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == StatAddr) |=> ((pendQ & $past(pendQ & wrData)) == $past(pendQ & wrData)));

  // R10: pending never falls without a status write
  a_r10_no_stray_clear: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == StatAddr) |=> ((pendQ & $past(pendQ)) == $past(pendQ)));

  // R10: reads of unmapped offsets return zero
  a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr != MaskAddr && addr != StatAddr) |-> (rdData == '0));

  // R9: an all-zero enable register one cycle back keeps the request low
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(maskQ) == '0) |-> !irqOut);
endmodule

bind irq_gather irq_gather_chk #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W),
  .MASK_OFS(MASK_OFS),
  .STAT_OFS(STAT_OFS)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .srcIn (srcIn),
  .addr  (addr),
  .wrEn  (wrEn),
  .rdEn  (rdEn),
  .wrData(wrData),
  .rdData(rdData),
  .irqOut(irqOut),
  .pendQ (pendQ),
  .maskQ (maskQ)
);

// File: tb/irq_gather_tb.sv
module irq_gather_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_MASK = 8'h00;
  localparam logic [7:0] A_STAT = 8'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] mMask = '0;
  logic [31:0] mPend = '0;
  logic [31:0] mProt = '0;
  logic        mIrq = 1'b0;
  logic [31:0] lastRd;

  irq_gather u_dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] expRead(logic rd, logic [7:0] a);
    if (!rd) return '0;
    if (a == A_MASK) return mMask;
    if (a == A_STAT) return mPend;
    return '0;
  endfunction

  function automatic string readTag(logic [7:0] a);
    if (a == A_MASK) return "R2";
    if (a == A_STAT) return "R4";
    return "R10";
  endfunction

  task automatic expectEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [31:0] s, logic [7:0] a, logic wr, logic rd, logic [31:0] wd);
    logic        accStat;
    logic [31:0] keep;
    @(negedge clk);
    srcIn = s; addr = a; wrEn = wr; rdEn = rd; wrData = wd;
    #1;
    lastRd = rdData;
    if (rd) expectEq(readTag(a), rdData, expRead(rd, a));
    @(posedge clk);
    accStat = (wr || rd) && a == A_STAT;
    keep    = (wr && a == A_STAT) ? (wd | mProt) : '1;
    mIrq    = |(mPend & mMask);
    mPend   = (mPend & keep) | s;
    mProt   = accStat ? s : (mProt | s);
    if (wr && a == A_MASK) mMask = wd;
    #1;
    expectEq("R9", {31'b0, irqOut}, {31'b0, mIrq});
  endtask

  task automatic rdChk(logic [7:0] a, logic [31:0] exp, string tag);
    cyc('0, a, 1'b0, 1'b1, '0);
    expectEq(tag, lastRd, exp);
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishUp();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    #1 expectEq("R1", {31'b0, irqOut}, 32'd0);
    rdChk(A_MASK, 32'h0, "R1");
    rdChk(A_STAT, 32'h0, "R1");
    // R3 sources latch while disabled
    cyc(32'h5, A_MASK, 1'b0, 1'b0, '0);
    rdChk(A_STAT, 32'h5, "R3");
    expectEq("R3", {31'b0, irqOut}, 32'd0);
    // R2 enable write and read-back, then request rises
    cyc('0, A_MASK, 1'b1, 1'b0, 32'hA5A5_0001);
    rdChk(A_MASK, 32'hA5A5_0001, "R2");
    expectEq("R9", {31'b0, irqOut}, 32'd1);
    // R5 clear bit 0 only
    cyc('0, A_STAT, 1'b1, 1'b0, 32'hFFFF_FFFE);
    rdChk(A_STAT, 32'h4, "R5");
    expectEq("R9", {31'b0, irqOut}, 32'd0);
    // R6 set in same cycle as clear-all
    cyc(32'h8, A_STAT, 1'b1, 1'b0, 32'h0);
    rdChk(A_STAT, 32'h8, "R6");
    // R7 source fires between read and write-back
    cyc(32'h100, A_MASK, 1'b0, 1'b0, '0);
    cyc('0, A_STAT, 1'b1, 1'b0, 32'h0);
    rdChk(A_STAT, 32'h100, "R7");
    // R8 clear-all with nothing protected
    cyc('0, A_STAT, 1'b1, 1'b0, 32'h0);
    rdChk(A_STAT, 32'h0, "R8");
    // R10 unmapped write and read
    cyc('0, 8'h04, 1'b1, 1'b0, 32'hFFFF_FFFF);
    rdChk(8'h04, 32'h0, "R10");
    rdChk(A_MASK, 32'hA5A5_0001, "R10");
    rdChk(A_STAT, 32'h0, "R10");
    // R8 enable zero silences the request
    cyc(32'h1, A_MASK, 1'b0, 1'b0, '0);
    cyc('0, A_MASK, 1'b0, 1'b0, '0);
    expectEq("R9", {31'b0, irqOut}, 32'd1);
    cyc('0, A_MASK, 1'b1, 1'b0, 32'h0);
    cyc('0, A_MASK, 1'b0, 1'b0, '0);
    expectEq("R8", {31'b0, irqOut}, 32'd0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] s;
      logic [7:0]  a;
      int          op;
      s  = $urandom & $urandom & $urandom & $urandom;
      op = $urandom_range(0, 9);
      case ($urandom_range(0, 3))
        0: a = A_MASK;
        1, 2: a = A_STAT;
        default: a = 8'h14;
      endcase
      if (op < 3) cyc(s, a, 1'b0, 1'b1, '0);
      else if (op < 5) cyc(s, a, 1'b1, 1'b0, $urandom);
      else if (op == 5) cyc(s, A_STAT, 1'b1, 1'b0, mPend & ~(32'h1 << $urandom_range(0, 31)));
      else cyc(s, a, 1'b0, 1'b0, '0);
    end
    finishUp();
  end
endmodule